// File: doc/BRIEF.md
# Zero-Operand Stack Execution Unit

This block executes a stream of stack-machine instructions one at a time. No instruction names a register. A PUSH copies a word from a data memory address onto the top of a stack. A POP removes the top word and stores it at a data memory address. Each binary arithmetic or logic instruction takes its two operands off the stack and leaves its single result there. The data memory and the stack share one word-addressed array. The upper `STACK_DEPTH` words of that array hold the stack. A stack pointer marks the current top element and moves toward lower addresses as the stack fills.

Instructions arrive over a valid/ready handshake. Each one carries a 3-bit opcode and an address field. When an instruction finishes, the unit raises a one-cycle completion pulse. The pulse comes with the word that was moved or computed and with overflow and underflow flags. A load port writes the data memory directly, so a surrounding block can place operands there before a run.

The current stack pointer is visible at the ports. A value of `2**ADDR_W` means the stack is empty.

Top module: `stack_engine`

## Requirements
- R1: After reset the stack pointer equals `2**ADDR_W` (empty stack), `instReady` is 1 and `doneValid` is 0.
- R2: Opcode 0 (PUSH) reads the word at `instAddr`, decrements the stack pointer, then writes the word at the new pointer; `doneData` returns that word.
- R3: Opcode 1 (POP) reads the word at the stack pointer, writes it to `instAddr`, then increments the pointer; `doneData` returns that word.
- R4: Opcodes 2 ADD, 3 SUB, 4 AND, 5 OR and 6 MUL take the top word as the right operand and the word beneath it as the left operand. The result overwrites the lower slot and the pointer rises by one, so SUB yields left minus right.
- R5: A PUSH issued when the stack already holds `STACK_DEPTH` words sets `doneOverflow`. That PUSH writes nothing and leaves the pointer unchanged. The pointer never leaves the range `2**ADDR_W - STACK_DEPTH` to `2**ADDR_W`.
- R6: A POP on an empty stack, or a binary opcode with fewer than two words on the stack, sets `doneUnderflow` and returns `doneData` 0. Memory and the pointer stay unchanged in that case. Either flag is only ever high together with `doneValid`.
- R7: An instruction is taken when `instValid` and `instReady` are both 1. `instReady` stays 0 from then until completion. `doneValid` is a single-cycle pulse, one per instruction taken. The pointer moves by at most one per cycle.
- R8: Opcode 7 is a no-operation: it completes with no flag, `doneData` 0, and no change to memory or the pointer.
- R9: Arithmetic wraps modulo 2^16 and MUL keeps the low 16 bits of the product.
- R10: A cycle with `loadEn` high writes `loadData` to `loadAddr`, and a later PUSH of that address returns the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Unit idle and able to take an instruction |
| instOp | input | 3 | Opcode: 0 PUSH, 1 POP, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 MUL, 7 no-op |
| instAddr | input | ADDR_W | Memory address for PUSH and POP |
| loadEn | input | 1 | Direct memory write strobe |
| loadAddr | input | ADDR_W | Direct write address |
| loadData | input | DATA_W | Direct write word |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | DATA_W | Word moved or computed, 0 on error or no-op |
| doneOverflow | output | 1 | Completed instruction hit a full stack |
| doneUnderflow | output | 1 | Completed instruction lacked stack operands |
| stackPtr | output | ADDR_W+1 | Current top-of-stack address |

## Verification
The assertions assume that the load port is used only while the unit is idle. They also assume that PUSH and POP addresses point below the stack region, so that user data and stack slots never alias. The bench drives the load port only between instructions and keeps every PUSH and POP address within the data words under the stack. Inside those limits, the bench sweeps every data address, every binary opcode over many operand pairs (including all-ones values that wrap), and the stack boundaries from empty to full.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0, OP_POP = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
    OP_AND  = 3'd4, OP_OR  = 3'd5, OP_MUL = 3'd6, OP_NOP = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {RD_INST, RD_TOP, RD_NEXT} rdSel_e;
  typedef enum logic [1:0] {WR_PUSH, WR_POP, WR_BIN} wrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    rdSel_e rdSel;
    logic   capLeft;
    logic   capRight;
    logic   memWr;
    wrSel_e wrSel;
    logic   clrRes;
  } strobe_t;
endpackage

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int STACK_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  opcode_e             opQ,
  input  logic [ADDR_W-1:0]   addrQ,
  input  logic                loadEn,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic [DATA_W-1:0]   loadData,
  output logic [ADDR_W:0]     stackPtr,
  output logic [DATA_W-1:0]   result,
  output logic                isFull,
  output logic                isEmpty,
  output logic                hasTwo
);
  localparam int MEM_WORDS   = 1 << ADDR_W;
  localparam int SP_W        = ADDR_W + 1;
  localparam int STACK_LIMIT = MEM_WORDS - STACK_DEPTH;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [SP_W-1:0]   sp, spPlus1, spMinus1;
  logic [DATA_W-1:0] leftOp, rightOp, rdData, aluOut, wrData;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [2*DATA_W-1:0] product;

  assign spPlus1  = sp + SP_W'(1);
  assign spMinus1 = sp - SP_W'(1);
  assign isEmpty  = (sp == SP_W'(MEM_WORDS));
  assign isFull   = (sp == SP_W'(STACK_LIMIT));
  assign hasTwo   = (sp <= SP_W'(MEM_WORDS - 2));
  assign stackPtr = sp;

  always_comb begin
    unique case (strobe.rdSel)
      RD_TOP:  rdAddr = sp[ADDR_W-1:0];
      RD_NEXT: rdAddr = spPlus1[ADDR_W-1:0];
      default: rdAddr = addrQ;
    endcase
  end
  assign rdData = mem[rdAddr];

  assign product = {{DATA_W{1'b0}}, leftOp} * {{DATA_W{1'b0}}, rightOp};

  always_comb begin
    unique case (opQ)
      OP_ADD:  aluOut = leftOp + rightOp;
      OP_SUB:  aluOut = leftOp - rightOp;
      OP_AND:  aluOut = leftOp & rightOp;
      OP_OR:   aluOut = leftOp | rightOp;
      OP_MUL:  aluOut = product[DATA_W-1:0];
      default: aluOut = '0;
    endcase
  end

  always_comb begin
    unique case (strobe.wrSel)
      WR_PUSH: begin wrAddr = spMinus1[ADDR_W-1:0]; wrData = leftOp; end
      WR_POP:  begin wrAddr = addrQ;                wrData = leftOp; end
      default: begin wrAddr = spPlus1[ADDR_W-1:0];  wrData = aluOut; end
    endcase
  end

  // memory carries no reset; contents come from the load port
  always_ff @(posedge clk) begin
    if (strobe.memWr)  mem[wrAddr]   <= wrData;
    else if (loadEn)   mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= SP_W'(MEM_WORDS);
      leftOp  <= '0;
      rightOp <= '0;
      result  <= '0;
    end else begin
      if (strobe.capLeft)  leftOp  <= rdData;
      if (strobe.capRight) rightOp <= rdData;
      if (strobe.clrRes)   result  <= '0;
      else if (strobe.memWr) result <= wrData;
      if (strobe.memWr) begin
        if (strobe.wrSel == WR_PUSH) sp <= spMinus1;
        else                         sp <= spPlus1;
      end
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              isFull,
  input  logic              isEmpty,
  input  logic              hasTwo,
  output logic              instReady,
  output logic              doneValid,
  output logic              doneOverflow,
  output logic              doneUnderflow,
  output opcode_e           opQ,
  output logic [ADDR_W-1:0] addrQ,
  output strobe_t           strobe
);
  typedef enum logic [2:0] {S_IDLE, S_RIGHT, S_LEFT, S_WRITE, S_DONE} state_e;
  state_e  state;
  opcode_e opIn;
  logic    take, isBinary;

  assign opIn      = opcode_e'(instOp);
  assign instReady = (state == S_IDLE);
  assign doneValid = (state == S_DONE);
  assign take      = instValid && instReady;
  assign isBinary  = (opQ != OP_PUSH) && (opQ != OP_POP) && (opQ != OP_NOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= S_IDLE;
      opQ           <= OP_NOP;
      addrQ         <= '0;
      doneOverflow  <= 1'b0;
      doneUnderflow <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (take) begin
          opQ           <= opIn;
          addrQ         <= instAddr;
          doneOverflow  <= 1'b0;
          doneUnderflow <= 1'b0;
          unique case (opIn)
            OP_PUSH: if (isFull) begin doneOverflow <= 1'b1; state <= S_DONE; end
                     else state <= S_LEFT;
            OP_POP:  if (isEmpty) begin doneUnderflow <= 1'b1; state <= S_DONE; end
                     else state <= S_LEFT;
            OP_NOP:  state <= S_DONE;
            default: if (!hasTwo) begin doneUnderflow <= 1'b1; state <= S_DONE; end
                     else state <= S_RIGHT;
          endcase
        end
        S_RIGHT: state <= S_LEFT;
        S_LEFT:  state <= S_WRITE;
        S_WRITE: state <= S_DONE;
        default: begin
          state         <= S_IDLE;
          doneOverflow  <= 1'b0;
          doneUnderflow <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_INST;
    strobe.wrSel    = WR_BIN;
    strobe.clrRes   = take;
    unique case (state)
      S_RIGHT: begin
        strobe.rdSel    = RD_TOP;
        strobe.capRight = 1'b1;
      end
      S_LEFT: begin
        strobe.capLeft = 1'b1;
        if (opQ == OP_POP)  strobe.rdSel = RD_TOP;
        else if (isBinary)  strobe.rdSel = RD_NEXT;
        else                strobe.rdSel = RD_INST;
      end
      S_WRITE: begin
        strobe.memWr = 1'b1;
        if (opQ == OP_PUSH)     strobe.wrSel = WR_PUSH;
        else if (opQ == OP_POP) strobe.wrSel = WR_POP;
        else                    strobe.wrSel = WR_BIN;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [2:0]        instOp,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData,
  output logic              doneOverflow,
  output logic              doneUnderflow,
  output logic [ADDR_W:0]   stackPtr
);
  strobe_t           strobe;
  opcode_e           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic              isFull, isEmpty, hasTwo;

  stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instAddr(instAddr), .isFull(isFull), .isEmpty(isEmpty), .hasTwo(hasTwo),
    .instReady(instReady), .doneValid(doneValid), .doneOverflow(doneOverflow),
    .doneUnderflow(doneUnderflow), .opQ(opQ), .addrQ(addrQ), .strobe(strobe)
  );

  stk_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opQ(opQ), .addrQ(addrQ),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .stackPtr(stackPtr), .result(doneData), .isFull(isFull),
    .isEmpty(isEmpty), .hasTwo(hasTwo)
  );
endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter int ADDR_W      = 5,
  parameter int STACK_DEPTH = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            instReady,
  input logic            doneValid,
  input logic            doneOverflow,
  input logic            doneUnderflow,
  input logic [ADDR_W:0] stackPtr
);
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int SP_W      = ADDR_W + 1;
  localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(MEM_WORDS);
  localparam logic [SP_W-1:0] SP_FULL  = SP_W'(MEM_WORDS - STACK_DEPTH);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (stackPtr == SP_EMPTY && instReady && !doneValid));

  assert_sp_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stackPtr >= SP_FULL) && (stackPtr <= SP_EMPTY));

  assert_sp_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stackPtr == $past(stackPtr)) || (stackPtr == $past(stackPtr) + SP_W'(1)) ||
    (stackPtr == $past(stackPtr) - SP_W'(1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_busy_at_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !instReady);

  assert_flag_with_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneOverflow || doneUnderflow) |-> doneValid);

  assert_error_keeps_sp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && (doneOverflow || doneUnderflow)) |-> $stable(stackPtr));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOverflow && doneUnderflow));
endmodule

bind stack_engine stack_engine_chk #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .instReady(instReady), .doneValid(doneValid),
  .doneOverflow(doneOverflow), .doneUnderflow(doneUnderflow), .stackPtr(stackPtr)
);

// File: tb/test_stack_engine.sv
`timescale 1ns/1ps
module test_stack_engine;
  localparam int DW = 16, AW = 5, DEPTH = 8;
  localparam int WORDS = 1 << AW;
  localparam int LIMIT = WORDS - DEPTH;

  logic clk = 1'b0, rstN = 1'b0;
  logic instValid = 1'b0, loadEn = 1'b0;
  logic [2:0] instOp = '0;
  logic [AW-1:0] instAddr = '0, loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic instReady, doneValid, doneOverflow, doneUnderflow;
  logic [DW-1:0] doneData;
  logic [AW:0] stackPtr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] mdl [WORDS];
  int msp;

  always #2 clk = ~clk;

  stack_engine #(.DATA_W(DW), .ADDR_W(AW), .STACK_DEPTH(DEPTH)) i_stack_engine (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instOp(instOp), .instAddr(instAddr), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .doneValid(doneValid), .doneData(doneData),
    .doneOverflow(doneOverflow), .doneUnderflow(doneUnderflow), .stackPtr(stackPtr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = AW'(a); loadData = v;
    @(negedge clk);
    loadEn = 1'b0;
    mdl[a] = v;
  endtask

  task automatic run(input int op, input int addr, input string req);
    logic [DW-1:0] v, l, r;
    logic [2*DW-1:0] p;
    bit ov, ud;
    ov = 0; ud = 0; v = '0;
    case (op)
      0: if (msp == LIMIT) ov = 1;
         else begin v = mdl[addr]; msp--; mdl[msp] = v; end
      1: if (msp == WORDS) ud = 1;
         else begin v = mdl[msp]; mdl[addr] = v; msp++; end
      7: v = '0;
      default: if (msp > WORDS - 2) ud = 1;
        else begin
          r = mdl[msp]; l = mdl[msp+1];
          p = {{DW{1'b0}}, l} * {{DW{1'b0}}, r};
          case (op)
            2: v = l + r;
            3: v = l - r;
            4: v = l & r;
            5: v = l | r;
            default: v = p[DW-1:0];
          endcase
          mdl[msp+1] = v; msp++;
        end
    endcase
    @(negedge clk);
    while (!instReady) @(negedge clk);
    instValid = 1'b1; instOp = 3'(op); instAddr = AW'(addr);
    @(negedge clk);
    instValid = 1'b0;
    chk(!instReady, "R7", "ready while busy", int'(instReady), 0);
    while (!doneValid) @(negedge clk);
    chk(doneData == v, req, $sformatf("data op%0d", op), int'(doneData), int'(v));
    chk(doneOverflow == ov && doneUnderflow == ud, req, "flags ovf/udf",
        int'({doneOverflow, doneUnderflow}), int'({ov, ud}));
    chk(int'(stackPtr) == msp, req, "stack pointer", int'(stackPtr), msp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    msp = WORDS;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(stackPtr) == WORDS, "R1", "reset pointer", int'(stackPtr), WORDS);
    chk(instReady == 1'b1, "R1", "reset ready", int'(instReady), 1);
    chk(doneValid == 1'b0, "R1", "reset done", int'(doneValid), 0);

    // R10 preload all data words through the load port
    for (int a = 0; a < LIMIT; a++) load(a, DW'(a * 1237 + 5));
    run(0, 7, "R10");
    run(1, 7, "R3");

    // R2 / R3 sweep over every data address
    for (int a = 0; a < LIMIT; a++) begin
      run(0, a, "R2");
      run(1, LIMIT - 1 - a, "R3");
    end

    // R4 every binary opcode over several operand pairs
    for (int op = 2; op <= 6; op++)
      for (int k = 0; k < 6; k++) begin
        run(0, (3 * k) % LIMIT, "R2");
        run(0, (3 * k + op) % LIMIT, "R2");
        run(op, 0, "R4");
        run(1, (op * 5 + k) % LIMIT, "R3");
      end

    // R9 wrap corners
    load(0, 16'hFFFF); load(1, 16'h0001); load(2, 16'h8000);
    for (int op = 2; op <= 6; op++) begin
      run(0, 0, "R2"); run(0, 1, "R2"); run(op, 0, "R9"); run(1, 3, "R3");
      run(0, 1, "R2"); run(0, 0, "R2"); run(op, 0, "R9"); run(1, 3, "R3");
      run(0, 0, "R2"); run(0, 0, "R2"); run(op, 0, "R9"); run(1, 3, "R3");
      run(0, 2, "R2"); run(0, 2, "R2"); run(op, 0, "R9"); run(1, 3, "R3");
    end

    // R4 expression (X+Y)*(Q-Z) popped to a destination, then read back
    run(0, 5, "R2"); run(0, 6, "R2"); run(2, 0, "R4");
    run(0, 9, "R2"); run(0, 11, "R2"); run(3, 0, "R4");
    run(6, 0, "R4"); run(1, 15, "R3");
    run(0, 15, "R2"); run(1, 16, "R3");

    // R5 fill to the limit, then one push too many
    for (int i = 0; i < DEPTH; i++) run(0, 4 + i, "R2");
    run(0, 20, "R5");
    run(0, 21, "R5");
    for (int i = 0; i < DEPTH; i++) run(1, 12 + i, "R3");

    // R6 underflow paths, memory left intact
    run(1, 4, "R6");
    run(0, 4, "R6");
    for (int op = 2; op <= 6; op++) run(op, 0, "R6");
    run(1, 4, "R3");
    for (int op = 2; op <= 6; op++) run(op, 0, "R6");

    // R8 no-op on empty and non-empty stack
    run(7, 0, "R8");
    run(0, 8, "R2");
    run(7, 3, "R8");
    run(1, 9, "R3");
    run(0, 9, "R8");
    run(1, 9, "R3");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule